// File: doc/BRIEF.md
# Edge-Clocked Serial Fault Reporter

This block reports an 8-bit fault word on one open-drain diagnostic line. It has no bit clock of its own. Each falling edge of the PWM command input arrives as a filtered one-cycle strobe, and each strobe moves the line on to the next position of a repeating 32-position cycle. Positions 0 to 9 form a frame: a low start bit, then the eight fault bits with bit 1 first, then a high stop bit. Positions 10 to 31 leave the line released, so that it reads high through its pull-up.

The fault word is assembled from three sources: per-plug open-load flags, per-plug overcurrent flags, and global battery and module fault flags. Overcurrent flags are held until reset, which stands for power-down. All other flags are taken as they are each time the word is refreshed. The word is refreshed only while the line is idle between frames, so a frame that is being sent never changes part-way through. Before the first frame the word stays clear, so the first frame sends nine low bits.

Top module: `diag_frame_tx`

## Requirements
- R1: After reset the line is released (`line_pull`=0) and `fail_reg` reads 0, and both stay that way until the first strobe has taken effect.
- R2: A strobe first sampled at rising edge E0 changes `line_pull` at rising edge E0+DLY (DLY=2). The line does not change before that edge, and it does not change without a strobe.
- R3: Position 0 pulls the line low (`line_pull`=1). Position k, for k from 1 to 8, drives `line_pull` to the inverse of `fail_reg[k-1]`, so fault bit k sits at `fail_reg` index k-1. Position 9 and positions 10 to 31 release the line.
- R4: The first strobe after reset starts a frame. Its first nine bits are low even if faults were present before that strobe.
- R5: The position wraps after 32 strobes, so a new frame starts at every 32nd strobe.
- R6: `fail_reg` is refreshed only while the line is idle. That means after the stop bit of a frame and before the next start bit, and never before the first frame. Flags that change during a frame do not alter that frame.
- R7: With no overcurrent stored and no battery undervoltage, `fail_reg[5:0]` equals the open-load flags and `fail_reg[6]`=0.
- R8: An overcurrent pulse on a plug is stored until reset. While any overcurrent is stored, `fail_reg[6]`=1 and `fail_reg[5:0]` shows the stored overcurrent plugs in place of the open-load flags.
- R9: Battery undervoltage sets `fail_reg[7]` and `fail_reg[6]`, and holds `fail_reg[5:0]` at 0 while no overcurrent is stored.
- R10: Any module fault flag sets `fail_reg[7]`.
- R11: A non-stored flag that has cleared is absent from the word sent in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset (power-down) |
| fall_stb | input | 1 | One-cycle strobe for each filtered falling edge of the command input |
| open_load | input | N_PLUG | Per-plug open-load flags |
| over_cur | input | N_PLUG | Per-plug overcurrent flags, stored inside the block |
| bat_low | input | 1 | Battery undervoltage flag |
| module_flt | input | N_MOD | Module fault flags (switch, supply low/high, temperature, charge pump) |
| line_pull | output | 1 | Open-drain pull-low enable for the diagnostic line |
| fail_reg | output | N_PLUG+2 | Current fault word, index k-1 = fault bit k |

## Verification
A wrong position count shows up as a start bit on a strobe other than every 32nd, or as a pulled line in the idle stretch. It appears at the latest one frame after the error, at the first strobe that should have been idle or a start bit. A refresh let through at the wrong time shows up as a bit that changes between the start and stop bits of a frame, or as a non-zero first frame. A stored overcurrent that is lost shows up as `fail_reg[6]` falling in the next idle window and as the open-load pattern returning in the next frame.

// File: rtl/diag_tx_pkg.sv
package diag_tx_pkg;
  // Frame layout: start bit, data bits, stop bit.
  localparam int unsigned DATA_BITS = 8;
  localparam int unsigned FRAME_LEN = DATA_BITS + 2;

  typedef enum logic [1:0] {
    SEG_START = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STOP  = 2'd2,
    SEG_IDLE  = 2'd3
  } seg_e;

  function automatic seg_e seg_of(input int unsigned pos);
    if (pos == 0)                   return SEG_START;
    else if (pos <= DATA_BITS)      return SEG_DATA;
    else if (pos == DATA_BITS + 1)  return SEG_STOP;
    else                            return SEG_IDLE;
  endfunction
endpackage

// File: rtl/dtx_strobe_delay.sv
module dtx_strobe_delay #(
  parameter int unsigned DLY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic stb_in,
  output logic stb_out
);
  generate
    if (DLY == 0) begin : g_pass
      assign stb_out = stb_in;
    end else begin : g_pipe
      logic [DLY-1:0] pipe_q;
      always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[DLY-2 >= 0 ? DLY-2 : 0 : 0], stb_in};
      end
      assign stb_out = pipe_q[DLY-1];
    end
  endgenerate
endmodule

// File: rtl/dtx_oc_latch.sv
module dtx_oc_latch #(
  parameter int unsigned N_PLUG = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PLUG-1:0] oc_in,
  output logic [N_PLUG-1:0] oc_q
);
  generate
    for (genvar i = 0; i < N_PLUG; i++) begin : g_ch
      always_ff @(posedge clk) begin
        if (rst)          oc_q[i] <= 1'b0;
        else if (oc_in[i]) oc_q[i] <= 1'b1;
      end

      // Stored overcurrent survives until reset.
      assert_oc_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        oc_q[i] |=> oc_q[i]);
    end
  endgenerate
endmodule

// File: rtl/dtx_fault_word.sv
module dtx_fault_word #(
  parameter int unsigned N_PLUG = 6,
  parameter int unsigned N_MOD  = 5,
  localparam int unsigned W     = N_PLUG + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [N_PLUG-1:0] ol,
  input  logic [N_PLUG-1:0] oc_held,
  input  logic              bat_uv,
  input  logic [N_MOD-1:0]  mod_flt,
  output logic [W-1:0]      word_q
);
  logic              any_oc;
  logic [N_PLUG-1:0] plug_bits;
  logic [W-1:0]      word_d;

  always_comb begin
    any_oc = |oc_held;
    if (any_oc)      plug_bits = oc_held;
    else if (bat_uv) plug_bits = '0;
    else             plug_bits = ol;
    word_d = {(|mod_flt) | bat_uv, any_oc | bat_uv, plug_bits};
  end

  always_ff @(posedge clk) begin
    if (rst)        word_q <= '0;
    else if (wr_en) word_q <= word_d;
  end
endmodule

// File: rtl/dtx_frame_seq.sv
module dtx_frame_seq
  import diag_tx_pkg::*;
#(
  parameter int unsigned PERIOD = 32,
  parameter int unsigned REG_W  = DATA_BITS,
  localparam int unsigned CNT_W = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [REG_W-1:0] word,
  output logic             pull_q,
  output logic             wr_open
);
  logic [CNT_W-1:0] nxt_q;
  logic             started_q;
  logic             data_bit;
  logic             pull_d;
  seg_e             seg;

  always_comb begin
    seg      = seg_of(int'(nxt_q));
    data_bit = 1'b1;
    for (int k = 0; k < REG_W; k++)
      if (nxt_q == CNT_W'(k + 1)) data_bit = word[k];
    unique case (seg)
      SEG_START: pull_d = 1'b1;
      SEG_DATA:  pull_d = ~data_bit;
      default:   pull_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nxt_q     <= '0;
      started_q <= 1'b0;
      pull_q    <= 1'b0;
    end else if (adv) begin
      started_q <= 1'b1;
      pull_q    <= pull_d;
      nxt_q     <= (nxt_q == CNT_W'(PERIOD - 1)) ? '0 : nxt_q + 1'b1;
    end
  end

  assign wr_open = started_q && !adv &&
                   (nxt_q == '0 || int'(nxt_q) >= FRAME_LEN);

  assert_prestart_released_R1: assert property (@(posedge clk) disable iff (rst)
    !started_q |-> !pull_q);
  assert_hold_without_edge_R2: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(nxt_q) && $stable(pull_q));
  assert_start_pulls_R3: assert property (@(posedge clk) disable iff (rst)
    started_q && nxt_q == CNT_W'(1) |-> pull_q);
  assert_idle_released_R3: assert property (@(posedge clk) disable iff (rst)
    started_q && (nxt_q == '0 || int'(nxt_q) >= FRAME_LEN) |-> !pull_q);
endmodule

// File: rtl/diag_frame_tx.sv
module diag_frame_tx
  import diag_tx_pkg::*;
#(
  parameter int unsigned N_PLUG = 6,
  parameter int unsigned N_MOD  = 5,
  parameter int unsigned PERIOD = 32,
  parameter int unsigned DLY    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall_stb,
  input  logic [N_PLUG-1:0] open_load,
  input  logic [N_PLUG-1:0] over_cur,
  input  logic              bat_low,
  input  logic [N_MOD-1:0]  module_flt,
  output logic              line_pull,
  output logic [N_PLUG+1:0] fail_reg
);
  localparam int unsigned REG_W = N_PLUG + 2;

  logic              adv;
  logic              wr_open;
  logic [N_PLUG-1:0] oc_held;

  dtx_strobe_delay #(.DLY(DLY)) u_dly (
    .clk(clk), .rst(rst), .stb_in(fall_stb), .stb_out(adv));

  dtx_oc_latch #(.N_PLUG(N_PLUG)) u_oc (
    .clk(clk), .rst(rst), .oc_in(over_cur), .oc_q(oc_held));

  dtx_fault_word #(.N_PLUG(N_PLUG), .N_MOD(N_MOD)) u_word (
    .clk(clk), .rst(rst), .wr_en(wr_open), .ol(open_load),
    .oc_held(oc_held), .bat_uv(bat_low), .mod_flt(module_flt),
    .word_q(fail_reg));

  dtx_frame_seq #(.PERIOD(PERIOD), .REG_W(REG_W)) u_seq (
    .clk(clk), .rst(rst), .adv(adv), .word(fail_reg),
    .pull_q(line_pull), .wr_open(wr_open));

  // Word is frozen whenever the sequencer keeps the window closed.
  assert_frozen_in_frame_R6: assert property (@(posedge clk) disable iff (rst)
    !wr_open |=> $stable(fail_reg));
  // Battery undervoltage alone: both upper bits, plug bits clear.
  assert_bat_low_word_R9: assert property (@(posedge clk) disable iff (rst)
    wr_open && bat_low && oc_held == '0 && !(|over_cur) |=>
      fail_reg[N_PLUG+1:N_PLUG] == 2'b11 && fail_reg[N_PLUG-1:0] == '0);
endmodule

// File: tb/sim_diag_frame_tx.sv
module sim_diag_frame_tx;
  localparam int CLK_P = 10;
  localparam int NP    = 6;
  localparam int NM    = 5;
  localparam int DLY   = 2;

  typedef struct { logic exp; string tag; } item_t;

  logic          clk = 0;
  logic          rst = 1;
  logic          fall_stb = 0;
  logic [NP-1:0] open_load = '0;
  logic [NP-1:0] over_cur = '0;
  logic          bat_low = 0;
  logic [NM-1:0] module_flt = '0;
  logic          line_pull;
  logic [NP+1:0] fail_reg;

  int checks = 0;
  int fails  = 0;
  logic [NP-1:0] oc_seen = '0;
  item_t sb[$];

  always #(CLK_P/2) clk = ~clk;

  diag_frame_tx #(.N_PLUG(NP), .N_MOD(NM), .PERIOD(32), .DLY(DLY)) u0 (
    .clk(clk), .rst(rst), .fall_stb(fall_stb), .open_load(open_load),
    .over_cur(over_cur), .bat_low(bat_low), .module_flt(module_flt),
    .line_pull(line_pull), .fail_reg(fail_reg));

  function automatic logic [NP+1:0] model();
    logic [NP-1:0] pb;
    if (|oc_seen)    pb = oc_seen;
    else if (bat_low) pb = '0;
    else             pb = open_load;
    return {(|module_flt) | bat_low, (|oc_seen) | bat_low, pb};
  endfunction

  task automatic chk_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s line_pull act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic chk_reg(input logic [NP+1:0] exp, input string tag);
    checks++;
    if (fail_reg !== exp) begin
      fails++;
      $display("FAIL %s fail_reg act=%h exp=%h", tag, fail_reg, exp);
    end
  endtask

  // Monitor: pops one expected line value per strobe after the latency.
  initial forever begin
    item_t it;
    wait (sb.size() > 0);
    repeat (DLY + 1) @(posedge clk);
    @(negedge clk);
    it = sb.pop_front();
    chk_bit(line_pull, it.exp, it.tag);
  end

  // Driver: queue the expectation, then pulse the strobe.
  task automatic edge_push(input logic exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    fall_stb = 1;
    @(posedge clk);
    @(negedge clk);
    fall_stb = 0;
    repeat (DLY + 1) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] w, input int lo, input int hi, input string tag);
    for (int i = lo; i <= hi; i++) begin
      if (i == 0)      edge_push(1'b1, {tag, " R5 start"});
      else if (i <= 8) edge_push(~w[i-1], {tag, " R3 data"});
      else             edge_push(1'b0, {tag, " R3 stop"});
    end
  endtask

  task automatic idle_edges();
    for (int i = 10; i < 32; i++) edge_push(1'b0, "R3 idle");
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] w;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk_bit(line_pull, 1'b0, "R1 reset line");
    chk_reg('0, "R1 reset word");

    // Faults present before the first frame: word must stay clear (R4).
    open_load = 6'b000101;
    settle();
    chk_reg('0, "R4 word clear before first frame");
    chk_bit(line_pull, 1'b0, "R1 released before first edge");

    // First strobe by hand to check the latency (R2).
    fall_stb = 1;
    @(posedge clk);
    @(negedge clk);
    fall_stb = 0;
    for (int i = 1; i < DLY; i++) begin
      chk_bit(line_pull, 1'b0, "R2 no early change");
      @(negedge clk);
    end
    chk_bit(line_pull, 1'b0, "R2 no early change");
    @(negedge clk);
    chk_bit(line_pull, 1'b1, "R2 R4 start bit at latency");
    @(negedge clk);
    send_bits(8'h00, 1, 9, "R4 first frame");
    idle_edges();
    chk_reg(model(), "R7 open-load word");
    chk_reg(8'h05, "R7 open-load literal");

    // Second frame: flags change mid-frame (R6), then dropped (R11).
    send_bits(8'h05, 0, 3, "R6 frame2");
    open_load = 6'b111000;
    settle();
    chk_reg(8'h05, "R6 word frozen mid-frame");
    send_bits(8'h05, 4, 9, "R6 frame2");
    idle_edges();
    chk_reg(8'h38, "R11 cleared open-load dropped");

    // Module fault only (R10).
    open_load = '0; module_flt = 5'b00100;
    settle();
    chk_reg(8'h80, "R10 module fault");
    send_bits(8'h38 ^ 8'h38 | 8'h80, 0, 9, "R10 frame3");
    idle_edges();

    // Battery undervoltage hides open-load (R9).
    module_flt = '0; bat_low = 1; open_load = 6'b000011;
    settle();
    chk_reg(8'hC0, "R9 battery low");
    send_bits(8'hC0, 0, 9, "R9 frame4");
    idle_edges();

    // Overcurrent pulse on plug 4 (R8).
    bat_low = 0; open_load = 6'b000001;
    over_cur = 6'b001000; oc_seen = oc_seen | 6'b001000;
    @(negedge clk);
    over_cur = '0;
    settle();
    w = model();
    chk_reg(8'h48, "R8 overcurrent shown");
    send_bits(w, 0, 9, "R8 frame5");
    idle_edges();
    chk_reg(8'h48, "R8 overcurrent kept");

    // Overcurrent plus battery low: plug bits show overcurrent (R8 R9).
    bat_low = 1;
    settle();
    chk_reg(8'hC8, "R8 R9 overcurrent with battery low");
    send_bits(8'hC8, 0, 9, "R8 frame6");
    idle_edges();

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule